// File: doc/BRIEF.md
# Signal Reverse Translation Table

This block is a small, fully associative lookup table. It turns the physical address carried by an incoming signal into three values: a handler entry point, a virtual address in the current process, and a priority. With these the processor can jump straight to a user-level handler without going through the kernel. Software fills the table whenever it switches to a process that has signal handlers defined. It can clear one entry or the whole table.

A lookup compares the physical page number against every valid entry in parallel. When the lowest-indexed matching entry is found, that entry's handler address and virtual page are returned. The page offset of the request is carried through into the returned virtual address. The priority is not a separate field: it is taken from the low bits of the virtual address that was written into the entry.

When no entry matches, the table does not fault. It returns a fixed default handler address and passes the physical address through unchanged as the virtual address. Every result is registered and appears one cycle after the request.

Top module: `sig_rev_xlate`

## Requirements
- R1: After reset every entry is invalid and `rsp_valid` is low.
- R2: Each request with `req_valid` high gives exactly one response. `rsp_valid` is high in the cycle after the request and low otherwise.
- R3: A lookup hits when a valid entry's page number equals `req_pa[ADDR_W-1:OFS_W]`. On a hit, `rsp_hit` is 1 and `rsp_pc` is that entry's handler address.
- R4: On a hit, `rsp_va` is the entry's virtual page (`wr_va[ADDR_W-1:OFS_W]` at write time) followed by the request's offset `req_pa[OFS_W-1:0]`. The middle bits of `wr_va` are ignored.
- R5: On a hit, `rsp_prio` is `wr_va[PRIO_W-1:0]` as written. `rsp_user` is 1 exactly when that priority is 0, the user-mode level.
- R6: On a miss, `rsp_hit` is 0, `rsp_pc` equals `DEFAULT_PC`, `rsp_va` equals `req_pa`, `rsp_prio` is all ones, and `rsp_user` is 0.
- R7: When several valid entries match, the entry with the lowest index supplies the result.
- R8: `inv_en` clears entry `wr_idx`. When `wr_en` and `inv_en` are both high, the entry ends up invalid.
- R9: `inv_all` clears every entry in one cycle and overrides any write or invalidate in the same cycle.
- R10: A lookup in the same cycle as a write or an invalidate sees the table as it was before that cycle. A write to a valid entry replaces all of its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Load entry `wr_idx` and mark it valid |
| inv_en | input | 1 | Invalidate entry `wr_idx` |
| inv_all | input | 1 | Invalidate every entry |
| wr_idx | input | IDX_W | Entry selected for a load or an invalidate |
| wr_ppn | input | ADDR_W-OFS_W | Physical page number to match |
| wr_va | input | ADDR_W | Virtual page in the upper bits, priority in the low PRIO_W bits |
| wr_pc | input | PC_W | Handler entry point |
| req_valid | input | 1 | Lookup request |
| req_pa | input | ADDR_W | Physical address to translate |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_hit | output | 1 | A valid entry matched |
| rsp_pc | output | PC_W | Handler entry point |
| rsp_va | output | ADDR_W | Translated virtual address |
| rsp_prio | output | PRIO_W | Signal priority |
| rsp_user | output | 1 | Priority is the user-mode level |

## Verification
The bench builds the table with a 16-bit address, an 8-bit offset, four entries, a 2-bit priority and a 16-bit handler address. These small widths make every one of the 256 physical page numbers reachable in one sweep, so each table state is checked against every page rather than a sample. Sweeps are repeated after loading, after duplicate pages are set up, after single and full invalidation, and after a write that overlaps a lookup. Together these cover priority selection, invalidation races and the read-before-write ordering.

// File: rtl/sig_rev_xlate_pkg.sv
package sig_rev_xlate_pkg;

    typedef enum logic {
        LK_MISS = 1'b0,
        LK_HIT  = 1'b1
    } lk_e;

    localparam int unsigned USER_PRIO = 0;

    function automatic logic is_user(input int unsigned prio);
        return prio == USER_PRIO;
    endfunction

endpackage

// File: rtl/sig_rev_xlate_slot.sv
module sig_rev_xlate_slot #(
    parameter int PPN_W  = 8,
    parameter int VPN_W  = 8,
    parameter int PC_W   = 16,
    parameter int PRIO_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inv_all,
    input  logic              wr_sel,
    input  logic              inv_sel,
    input  logic [PPN_W-1:0]  wr_ppn,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [PRIO_W-1:0] wr_prio,
    input  logic [PC_W-1:0]   wr_pc,
    input  logic [PPN_W-1:0]  lk_ppn,
    output logic              valid,
    output logic              match,
    output logic [VPN_W-1:0]  vpn,
    output logic [PRIO_W-1:0] prio,
    output logic [PC_W-1:0]   pc
);

    logic [PPN_W-1:0] ppn_q;

    always_ff @(posedge clk) begin
        if (rst || inv_all || inv_sel) begin
            valid <= 1'b0;
        end else if (wr_sel) begin
            valid <= 1'b1;
        end
        if (wr_sel) begin
            ppn_q <= wr_ppn;
            vpn   <= wr_vpn;
            prio  <= wr_prio;
            pc    <= wr_pc;
        end
    end

    assign match = valid && (ppn_q == lk_ppn);

    p_inv_all_r9: assert property (@(posedge clk) disable iff (rst)
        inv_all |=> !valid);

    p_inv_one_r8: assert property (@(posedge clk) disable iff (rst)
        inv_sel |=> !valid);

    p_load_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_sel && !inv_sel && !inv_all) |=> (valid && pc == $past(wr_pc) && vpn == $past(wr_vpn)));

endmodule

// File: rtl/sig_rev_xlate_pick.sv
module sig_rev_xlate_pick #(
    parameter int N = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     match,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

    p_lowest_r7: assert property (@(posedge clk) disable iff (rst)
        hit |-> (match[idx] && ((match & ((N'(1) << idx) - N'(1))) == '0)));

    p_none_r6: assert property (@(posedge clk) disable iff (rst)
        (match == '0) |-> !hit);

endmodule

// File: rtl/sig_rev_xlate.sv
module sig_rev_xlate
    import sig_rev_xlate_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int OFS_W   = 12,
    parameter int PC_W    = 32,
    parameter int PRIO_W  = 2,
    parameter int ENTRIES = 8,
    parameter logic [PC_W-1:0] DEFAULT_PC = '0,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int PPN_W = ADDR_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              inv_en,
    input  logic              inv_all,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [PPN_W-1:0]  wr_ppn,
    input  logic [ADDR_W-1:0] wr_va,
    input  logic [PC_W-1:0]   wr_pc,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_pa,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PC_W-1:0]   rsp_pc,
    output logic [ADDR_W-1:0] rsp_va,
    output logic [PRIO_W-1:0] rsp_prio,
    output logic              rsp_user
);

    localparam logic [PRIO_W-1:0] MISS_PRIO = '1;

    logic [ENTRIES-1:0] slot_valid;
    logic [ENTRIES-1:0] slot_match;
    logic [PPN_W-1:0]   slot_vpn  [ENTRIES];
    logic [PRIO_W-1:0]  slot_prio [ENTRIES];
    logic [PC_W-1:0]    slot_pc   [ENTRIES];
    logic               any_hit;
    logic [IDX_W-1:0]   hit_idx;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        sig_rev_xlate_slot #(
            .PPN_W (PPN_W),
            .VPN_W (PPN_W),
            .PC_W  (PC_W),
            .PRIO_W(PRIO_W)
        ) u_slot (
            .clk    (clk),
            .rst    (rst),
            .inv_all(inv_all),
            .wr_sel (wr_en && (wr_idx == IDX_W'(g))),
            .inv_sel(inv_en && (wr_idx == IDX_W'(g))),
            .wr_ppn (wr_ppn),
            .wr_vpn (wr_va[ADDR_W-1:OFS_W]),
            .wr_prio(wr_va[PRIO_W-1:0]),
            .wr_pc  (wr_pc),
            .lk_ppn (req_pa[ADDR_W-1:OFS_W]),
            .valid  (slot_valid[g]),
            .match  (slot_match[g]),
            .vpn    (slot_vpn[g]),
            .prio   (slot_prio[g]),
            .pc     (slot_pc[g])
        );
    end

    sig_rev_xlate_pick #(.N(ENTRIES)) u_pick (
        .clk  (clk),
        .rst  (rst),
        .match(slot_match),
        .hit  (any_hit),
        .idx  (hit_idx)
    );

    lk_e lk_res;
    assign lk_res = any_hit ? LK_HIT : LK_MISS;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_pc    <= '0;
            rsp_va    <= '0;
            rsp_prio  <= '0;
            rsp_user  <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                if (lk_res == LK_HIT) begin
                    rsp_hit  <= 1'b1;
                    rsp_pc   <= slot_pc[hit_idx];
                    rsp_va   <= {slot_vpn[hit_idx], req_pa[OFS_W-1:0]};
                    rsp_prio <= slot_prio[hit_idx];
                    rsp_user <= is_user(int'(slot_prio[hit_idx]));
                end else begin
                    rsp_hit  <= 1'b0;
                    rsp_pc   <= DEFAULT_PC;
                    rsp_va   <= req_pa;
                    rsp_prio <= MISS_PRIO;
                    rsp_user <= 1'b0;
                end
            end
        end
    end

    p_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rsp_valid && slot_valid == '0));

    p_resp_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    p_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    p_offset_r4: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (rsp_va[OFS_W-1:0] == $past(req_pa[OFS_W-1:0])));

    p_miss_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && slot_match == '0) |=>
            (!rsp_hit && rsp_va == $past(req_pa) && rsp_pc == DEFAULT_PC));

    p_flush_r9: assert property (@(posedge clk) disable iff (rst)
        inv_all |=> ($countones(slot_valid) == 0));

endmodule

// File: tb/sig_rev_xlate_tb.sv
module sig_rev_xlate_tb;

    localparam int AW = 16, OW = 8, PW = 16, QW = 2, NE = 4;
    localparam logic [PW-1:0] DPC = 16'hF000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 0, inv_en = 0, inv_all = 0, req_valid = 0;
    logic [1:0] wr_idx = '0;
    logic [7:0] wr_ppn = '0;
    logic [AW-1:0] wr_va = '0, req_pa = '0;
    logic [PW-1:0] wr_pc = '0;
    logic rsp_valid, rsp_hit, rsp_user;
    logic [PW-1:0] rsp_pc;
    logic [AW-1:0] rsp_va;
    logic [QW-1:0] rsp_prio;

    int n_chk = 0, n_err = 0;

    bit       m_v   [NE];
    bit [7:0] m_ppn [NE];
    bit [7:0] m_vpn [NE];
    bit [1:0] m_pr  [NE];
    bit [15:0] m_pc [NE];

    always #2ns clk = ~clk;

    sig_rev_xlate #(.ADDR_W(AW), .OFS_W(OW), .PC_W(PW), .PRIO_W(QW),
                    .ENTRIES(NE), .DEFAULT_PC(DPC)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .inv_en(inv_en), .inv_all(inv_all),
        .wr_idx(wr_idx), .wr_ppn(wr_ppn), .wr_va(wr_va), .wr_pc(wr_pc),
        .req_valid(req_valid), .req_pa(req_pa), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_pc(rsp_pc), .rsp_va(rsp_va),
        .rsp_prio(rsp_prio), .rsp_user(rsp_user));

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_write(input int i, input bit [7:0] ppn, input bit [15:0] va, input bit [15:0] pc);
        m_v[i] = 1; m_ppn[i] = ppn; m_vpn[i] = va[15:8]; m_pr[i] = va[1:0]; m_pc[i] = pc;
    endtask

    task automatic do_write(input int i, input bit [7:0] ppn, input bit [15:0] va, input bit [15:0] pc);
        wr_en = 1; wr_idx = 2'(i); wr_ppn = ppn; wr_va = va; wr_pc = pc;
        @(negedge clk);
        wr_en = 0;
        model_write(i, ppn, va, pc);
    endtask

    // compare a response against the model
    task automatic expect_resp(input logic [15:0] pa);
        int w = -1;
        for (int i = NE - 1; i >= 0; i--) if (m_v[i] && m_ppn[i] == pa[15:8]) w = i;
        check("R2 rsp_valid", 64'(rsp_valid), 64'(1));
        if (w >= 0) begin
            check("R3/R7 hit pc", {47'd0, rsp_hit, rsp_pc}, {47'd0, 1'b1, m_pc[w]});
            check("R4 va", 64'(rsp_va), 64'({m_vpn[w], pa[7:0]}));
            check("R5 prio", {61'd0, rsp_prio, rsp_user}, {61'd0, m_pr[w], m_pr[w] == 2'd0});
        end else begin
            check("R6 miss", {29'd0, rsp_hit, rsp_pc, rsp_va, rsp_prio, rsp_user},
                  {29'd0, 1'b0, DPC, pa, 2'b11, 1'b0});
        end
    endtask

    task automatic lookup(input logic [15:0] pa);
        req_valid = 1; req_pa = pa;
        @(negedge clk);
        req_valid = 0;
        expect_resp(pa);
    endtask

    task automatic sweep();
        for (int p = 0; p < 256; p++) lookup({8'(p), 8'((p * 37 + 5) & 255)});
        @(negedge clk);
        check("R2 idle", 64'(rsp_valid), 64'(0));
    endtask

    initial begin
        #(4ns * 200000);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        for (int i = 0; i < NE; i++) m_v[i] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        check("R1 reset", 64'(rsp_valid), 64'(0));
        sweep();                                   // R1, R6: empty table misses everywhere

        do_write(0, 8'h12, 16'h7A00, 16'h1000);    // prio 0 (user)
        do_write(1, 8'h34, 16'h5B01, 16'h1100);
        do_write(2, 8'hA0, 16'hC3FE, 16'h1200);    // middle bits ignored, prio 2
        do_write(3, 8'hFF, 16'h0003, 16'h1300);
        sweep();                                   // R3 R4 R5 R6

        do_write(3, 8'h34, 16'hEE02, 16'h1400);    // R10 replace, duplicate of 1
        do_write(2, 8'h34, 16'hDD01, 16'h1500);
        sweep();                                   // R7: entry 1 wins

        inv_en = 1; wr_idx = 2'd1; @(negedge clk); inv_en = 0; m_v[1] = 0;
        sweep();                                   // R8, R7: entry 2 now wins

        wr_en = 1; inv_en = 1; wr_idx = 2'd2; wr_ppn = 8'h55; wr_va = 16'h4400; wr_pc = 16'h1600;
        @(negedge clk); wr_en = 0; inv_en = 0; m_v[2] = 0;
        lookup(16'h5510);                          // R8: entry 2 invalid, miss
        lookup(16'h3420);                          // entry 3 wins

        // R10: lookup in same cycle as write sees the old table
        req_valid = 1; req_pa = 16'h7777; wr_en = 1; wr_idx = 2'd1; wr_ppn = 8'h77;
        wr_va = 16'h9900; wr_pc = 16'h1700;
        @(negedge clk); req_valid = 0; wr_en = 0;
        expect_resp(16'h7777);
        model_write(1, 8'h77, 16'h9900, 16'h1700);
        lookup(16'h7777);

        // R9: flush wins over a simultaneous write
        inv_all = 1; wr_en = 1; wr_idx = 2'd0; wr_ppn = 8'h66; wr_va = 16'h1100; wr_pc = 16'h1800;
        @(negedge clk); inv_all = 0; wr_en = 0;
        for (int i = 0; i < NE; i++) m_v[i] = 0;
        sweep();

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule